// File: doc/BRIEF.md
# Sleep Wake-Source Controller

This block owns the system sleep request and decides when sleep ends. Software reaches it through a simple register port with three 32-bit registers: a control word, a wake-enable mask and a wake-reason word. Eight raw trigger lines (keypad, lid, headphone, wireless, lid GPIO, microcontroller, touch and cartridge events) are edge-detected. When a trigger's enable bit is set, its edge is latched into the reason word. Any latched and enabled reason ends sleep and drives a level wake interrupt.

Software clears reason bits with a three-step sequence. It writes 1 to the bit to acknowledge it, reads the reason register, and then writes 0 to release the bit. A trigger edge that arrives while a bit is partway through this sequence is remembered, so the bit stays set after the release. A memory self-refresh status input appears as a read-only flag in the control word.

Trigger inputs are assumed to be synchronous to `clk`.

Top module: `slp_wake_ctrl`

## Requirements
- R1: After reset, `sleep_o` and `wake_irq_o` are 0, and the wake-enable and wake-reason registers read 0.
- R2: Register offsets are: control at 0x0, wake-enable at 0x4, wake-reason at 0x8. Writing control bit 0 with 1 sets `sleep_o`, and writing it with 0 clears `sleep_o`. Control bit 0 reads back the sleep state. Control bits 1 to 14 and 16 to 31 read 0.
- R3: Control bit 15 is read-only and returns `selfref_in`. Writing to bit 15 has no effect.
- R4: Only bits 1, 3, 4, 8, 19, 26, 30 and 31 exist in the wake-enable and wake-reason registers. All other bits read 0.
- R5: A 0-to-1 change on `trig_in[k]` sets reason bit k at the same clock edge, provided k is an implemented position and enable bit k is 1. Disabled positions and unimplemented positions never set a reason bit.
- R6: An enabled trigger edge clears `sleep_o` at the same clock edge. This holds even when the same cycle carries a write of 1 to control bit 0.
- R7: `wake_irq_o` is 1 exactly while some reason bit and its enable bit are both 1. If such a pair exists while sleeping, `sleep_o` is cleared at the next edge.
- R8: A reason bit is cleared only by this sequence: write 1 to it, then read the reason register, then write 0 to it. A write of 0 without both earlier steps leaves the bit set.
- R9: If an enabled edge on a bit arrives after its acknowledge and up to and including the cycle of the releasing write, the bit stays set after that write.
- R10: A write of 1 to control bit 0 is ignored while `wake_irq_o` is 1.
- R11: `reg_rvalid` is 1 in exactly the cycle after a `reg_rd` strobe, with `reg_rdata` valid in that cycle. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid when `reg_rvalid` is 1 |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd` |
| trig_in | input | DATA_W | Raw wake-trigger lines, one per bit position |
| selfref_in | input | 1 | Memory self-refresh status |
| sleep_o | output | 1 | Sleep request state |
| wake_irq_o | output | 1 | Wake interrupt, level |

## Verification
Two functions can fall in the same clock cycle, and each collision is forced deliberately by driving both events on the same negative clock edge.

The first collision is a sleep-entry write and an enabled trigger edge. The bench checks that `sleep_o` reads 0 and `wake_irq_o` reads 1 after that edge.

The second collision is the releasing write of 0 to an armed reason bit and a fresh trigger edge on that same bit. The bench then reads the reason register back and checks that the bit is still set. A later complete clear sequence must bring the bit back to 0.

// File: rtl/slp_wake_pkg.sv
package slp_wake_pkg;
   localparam int OFS_CTRL = 'h0;
   localparam int OFS_WEN  = 'h4;
   localparam int OFS_WHY  = 'h8;

   localparam logic [31:0] DEF_TRIG_MASK = 32'hC408_011A;

   typedef enum logic [1:0] {
      AK_IDLE  = 2'd0,
      AK_HELD  = 2'd1,
      AK_ARMED = 2'd2
   } ack_st_t;
endpackage

// File: rtl/slp_wake_cell.sv
module slp_wake_cell
   import slp_wake_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic wr_i,
   input  logic wbit_i,
   input  logic rd_i,
   output logic why_o
);
   ack_st_t st_q;
   logic    why_q;
   logic    pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= AK_IDLE;
         why_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         unique case (st_q)
            AK_IDLE: begin
               if (set_i) why_q <= 1'b1;
               if (wr_i && wbit_i && why_q) st_q <= AK_HELD;
            end
            AK_HELD: begin
               if (set_i) pend_q <= 1'b1;
               if (rd_i) st_q <= AK_ARMED;
            end
            AK_ARMED: begin
               if (wr_i && !wbit_i) begin
                  why_q  <= pend_q | set_i;
                  pend_q <= 1'b0;
                  st_q   <= AK_IDLE;
               end else if (set_i) begin
                  pend_q <= 1'b1;
               end
            end
            default: st_q <= AK_IDLE;
         endcase
      end
   end

   assign why_o = why_q;
endmodule

// File: rtl/slp_wake_regs.sv
module slp_wake_regs
   import slp_wake_pkg::*;
#(
   parameter int          DATA_W      = 32,
   parameter int          ADDR_W      = 4,
   parameter logic [DATA_W-1:0] TRIG_MASK = DEF_TRIG_MASK,
   parameter int          SLEEP_BIT   = 0,
   parameter int          SELFREF_BIT = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [DATA_W-1:0] why_i,
   input  logic              wake_now_i,
   input  logic              selfref_in,
   output logic [DATA_W-1:0] en_o,
   output logic              why_wr_o,
   output logic              why_rd_o,
   output logic              sleep_o,
   output logic              irq_o,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              reg_rvalid
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_WEN  = ADDR_W'(OFS_WEN);
   localparam logic [ADDR_W-1:0] A_WHY  = ADDR_W'(OFS_WHY);

   logic [DATA_W-1:0] en_q;
   logic              sleep_q;
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rdata_q;
   logic              rvalid_q;
   logic              hit_ctrl, hit_wen, hit_why;

   assign hit_ctrl = (reg_addr == A_CTRL);
   assign hit_wen  = (reg_addr == A_WEN);
   assign hit_why  = (reg_addr == A_WHY);

   assign why_wr_o = reg_wr && hit_why;
   assign why_rd_o = reg_rd && hit_why;
   assign irq_o    = |(why_i & en_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (reg_wr && hit_wen) begin
         en_q <= reg_wdata & TRIG_MASK;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sleep_q <= 1'b0;
      end else if (wake_now_i || irq_o) begin
         sleep_q <= 1'b0;
      end else if (reg_wr && hit_ctrl) begin
         sleep_q <= reg_wdata[SLEEP_BIT];
      end
   end

   always_comb begin
      rd_mux = '0;
      if (hit_ctrl) begin
         rd_mux[SLEEP_BIT]   = sleep_q;
         rd_mux[SELFREF_BIT] = selfref_in;
      end else if (hit_wen) begin
         rd_mux = en_q;
      end else if (hit_why) begin
         rd_mux = why_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= reg_rd;
         rdata_q  <= reg_rd ? rd_mux : '0;
      end
   end

   assign en_o       = en_q;
   assign sleep_o    = sleep_q;
   assign reg_rdata  = rdata_q;
   assign reg_rvalid = rvalid_q;
endmodule

// File: rtl/slp_wake_ctrl.sv
module slp_wake_ctrl
   import slp_wake_pkg::*;
#(
   parameter int                DATA_W      = 32,
   parameter int                ADDR_W      = 4,
   parameter logic [DATA_W-1:0] TRIG_MASK   = DEF_TRIG_MASK,
   parameter int                SLEEP_BIT   = 0,
   parameter int                SELFREF_BIT = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              reg_rvalid,
   input  logic [DATA_W-1:0] trig_in,
   input  logic              selfref_in,
   output logic              sleep_o,
   output logic              wake_irq_o
);
   if (DATA_W < 32) begin : g_bad_w
      $error("slp_wake_ctrl: DATA_W must be at least 32");
   end
   if (ADDR_W < 4) begin : g_bad_a
      $error("slp_wake_ctrl: ADDR_W must be at least 4");
   end
   if (SELFREF_BIT >= DATA_W || SLEEP_BIT == SELFREF_BIT) begin : g_bad_b
      $error("slp_wake_ctrl: control bit positions invalid");
   end

   logic [DATA_W-1:0] trig_q;
   logic [DATA_W-1:0] edge_en;
   logic [DATA_W-1:0] en_q;
   logic [DATA_W-1:0] why_q;
   logic              why_wr, why_rd;
   logic              wake_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_q <= '0;
      else        trig_q <= trig_in & TRIG_MASK;
   end

   assign edge_en  = (trig_in & TRIG_MASK) & ~trig_q & en_q;
   assign wake_now = |edge_en;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (TRIG_MASK[i]) begin : g_cell
         slp_wake_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (edge_en[i]),
            .wr_i   (why_wr),
            .wbit_i (reg_wdata[i]),
            .rd_i   (why_rd),
            .why_o  (why_q[i])
         );
      end else begin : g_none
         assign why_q[i] = 1'b0;
      end
   end

   slp_wake_regs #(
      .DATA_W      (DATA_W),
      .ADDR_W      (ADDR_W),
      .TRIG_MASK   (TRIG_MASK),
      .SLEEP_BIT   (SLEEP_BIT),
      .SELFREF_BIT (SELFREF_BIT)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_rd     (reg_rd),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .why_i      (why_q),
      .wake_now_i (wake_now),
      .selfref_in (selfref_in),
      .en_o       (en_q),
      .why_wr_o   (why_wr),
      .why_rd_o   (why_rd),
      .sleep_o    (sleep_o),
      .irq_o      (wake_irq_o),
      .reg_rdata  (reg_rdata),
      .reg_rvalid (reg_rvalid)
   );
endmodule

// File: rtl/slp_wake_chk.sv
module slp_wake_chk #(
   parameter int                DATA_W    = 32,
   parameter logic [DATA_W-1:0] TRIG_MASK = 32'hC408_011A
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_rd,
   input logic              reg_wr,
   input logic              en_wr,
   input logic              why_wr,
   input logic [DATA_W-1:0] trig_in,
   input logic [DATA_W-1:0] en_q,
   input logic [DATA_W-1:0] why_q,
   input logic              reg_rvalid,
   input logic              sleep_o,
   input logic              wake_irq_o
);
   logic [DATA_W-1:0] trig_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_prev <= '0;
      else        trig_prev <= trig_in;
   end

   a_r11_rvalid_follows_rd: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> reg_rvalid);

   a_r11_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> !reg_rvalid);

   a_r7_irq_ends_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      wake_irq_o |=> !sleep_o);

   a_r5_edge_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(trig_in & ~trig_prev & TRIG_MASK & en_q)) && !en_wr) |=> wake_irq_o);

   a_r8_fall_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(why_q) & ~why_q)) |-> $past(why_wr));

   a_r4_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((why_q & ~TRIG_MASK) == '0) && !(reg_wr && 1'b0));
endmodule

bind slp_wake_ctrl slp_wake_chk #(
   .DATA_W    (DATA_W),
   .TRIG_MASK (TRIG_MASK)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_rd     (reg_rd),
   .reg_wr     (reg_wr),
   .en_wr      (reg_wr && (reg_addr == ADDR_W'(slp_wake_pkg::OFS_WEN))),
   .why_wr     (why_wr),
   .trig_in    (trig_in),
   .en_q       (en_q),
   .why_q      (why_q),
   .reg_rvalid (reg_rvalid),
   .sleep_o    (sleep_o),
   .wake_irq_o (wake_irq_o)
);

// File: tb/slp_wake_ctrl_tb.sv
`timescale 1ns/1ps
module slp_wake_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata, trig_in = '0;
   logic        reg_rvalid, selfref_in = 1'b0, sleep_o, wake_irq_o;
   int          checks = 0, errors = 0;
   bit          done = 1'b0;
   logic [31:0] rd;

   always #2.5 clk = ~clk;

   slp_wake_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .reg_rvalid(reg_rvalid), .trig_in(trig_in), .selfref_in(selfref_in),
      .sleep_o(sleep_o), .wake_irq_o(wake_irq_o));

   localparam logic [3:0] CT = 4'h0, EN = 4'h4, WY = 4'h8;
   localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TG = 2'd2;
   localparam int NV = 17;
   // {op, addr, data, expected read, expected irq, expected sleep}
   localparam logic [71:0] VEC [NV] = '{
      {OP_RD, CT, 32'h0, 32'h0, 1'b0, 1'b0},                 // R1
      {OP_RD, EN, 32'h0, 32'h0, 1'b0, 1'b0},                 // R1
      {OP_RD, WY, 32'h0, 32'h0, 1'b0, 1'b0},                 // R1
      {OP_WR, EN, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0},         // R4
      {OP_RD, EN, 32'h0, 32'hC408_011A, 1'b0, 1'b0},         // R4
      {OP_WR, CT, 32'h0000_FFFF, 32'h0, 1'b0, 1'b1},         // R2
      {OP_RD, CT, 32'h0, 32'h0000_0001, 1'b0, 1'b1},         // R2 R3
      {OP_TG, CT, 32'h0000_0008, 32'h0, 1'b1, 1'b0},         // R5 R6
      {OP_RD, WY, 32'h0, 32'h0000_0008, 1'b1, 1'b0},         // R5
      {OP_RD, CT, 32'h0, 32'h0, 1'b1, 1'b0},                 // R6
      {OP_WR, WY, 32'h0000_0008, 32'h0, 1'b1, 1'b0},         // R8
      {OP_RD, WY, 32'h0, 32'h0000_0008, 1'b1, 1'b0},         // R8
      {OP_WR, WY, 32'h0, 32'h0, 1'b0, 1'b0},                 // R8 R7
      {OP_RD, WY, 32'h0, 32'h0, 1'b0, 1'b0},                 // R8
      {OP_TG, CT, 32'h0000_0004, 32'h0, 1'b0, 1'b0},         // R5
      {OP_RD, WY, 32'h0, 32'h0, 1'b0, 1'b0},                 // R5
      {OP_RD, 4'hC, 32'h0, 32'h0, 1'b0, 1'b0}                // R11
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic do_rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk); reg_rd = 1'b1; reg_addr = a;
      @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
      chk("R11 rvalid", {31'b0, reg_rvalid}, 32'h1);
   endtask

   task automatic pulse(input logic [31:0] m);
      @(negedge clk); trig_in = trig_in | m;
      @(negedge clk); trig_in = trig_in & ~m;
   endtask

   task automatic clear(input logic [31:0] m);
      logic [31:0] t;
      do_wr(WY, m); do_rd(WY, t); do_wr(WY, 32'h0);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 sleep", {31'b0, sleep_o}, 32'h0);
      chk("R1 irq", {31'b0, wake_irq_o}, 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [71:0] v;
         v = VEC[i];
         if (v[71:70] == OP_WR) do_wr(v[69:66], v[65:34]);
         else if (v[71:70] == OP_TG) pulse(v[65:34]);
         else begin
            do_rd(v[69:66], rd);
            chk($sformatf("table row %0d read (R1-R11 per row)", i), rd, v[33:2]);
         end
         chk($sformatf("table row %0d irq R7", i), {31'b0, wake_irq_o}, {31'b0, v[1]});
         chk($sformatf("table row %0d sleep R2", i), {31'b0, sleep_o}, {31'b0, v[0]});
      end

      // R3: self-refresh flag mirrored, write has no effect
      selfref_in = 1'b1;
      do_wr(CT, 32'h0);
      do_rd(CT, rd); chk("R3 flag set", rd, 32'h0000_8000);
      selfref_in = 1'b0;
      do_rd(CT, rd); chk("R3 flag clear", rd, 32'h0);
      @(negedge clk); chk("R11 rvalid low after", {31'b0, reg_rvalid}, 32'h0);

      // R8: incomplete sequences leave the bit set
      pulse(32'h2);
      do_wr(WY, 32'h0);
      do_rd(WY, rd); chk("R8 zero without ack", rd, 32'h2);
      do_wr(WY, 32'h2); do_wr(WY, 32'h0);
      do_rd(WY, rd); chk("R8 zero without read", rd, 32'h2);
      do_wr(WY, 32'h0);
      do_rd(WY, rd); chk("R8 complete clear", rd, 32'h0);

      // R9: edge during acknowledge stays pending
      pulse(32'h4000_0000);
      do_wr(WY, 32'h4000_0000);
      pulse(32'h4000_0000);
      do_rd(WY, rd);
      do_wr(WY, 32'h0);
      do_rd(WY, rd); chk("R9 pending kept", rd, 32'h4000_0000);
      chk("R9 irq kept", {31'b0, wake_irq_o}, 32'h1);
      do_wr(WY, 32'h4000_0000); do_rd(WY, rd);
      @(negedge clk); reg_wr = 1'b1; reg_addr = WY; reg_wdata = 32'h0; trig_in = 32'h4000_0000;
      @(negedge clk); reg_wr = 1'b0; trig_in = 32'h0;
      do_rd(WY, rd); chk("R9 same-cycle edge kept", rd, 32'h4000_0000);
      clear(32'h4000_0000);
      do_rd(WY, rd); chk("R9 final clear", rd, 32'h0);

      // R5: disabled trigger ignored; R10 and R7 wake via enable
      do_wr(EN, 32'h0);
      pulse(32'h8000_0000);
      do_rd(WY, rd); chk("R5 disabled ignored", rd, 32'h0);
      do_wr(EN, 32'hC408_011A);
      pulse(32'h0000_0010);
      do_wr(EN, 32'h0);
      chk("R7 irq off when disabled", {31'b0, wake_irq_o}, 32'h0);
      do_wr(CT, 32'h1);
      chk("R2 sleep enters", {31'b0, sleep_o}, 32'h1);
      do_wr(EN, 32'h0000_0010);
      chk("R7 irq on", {31'b0, wake_irq_o}, 32'h1);
      @(negedge clk);
      chk("R7 sleep ends", {31'b0, sleep_o}, 32'h0);
      do_wr(CT, 32'h1);
      chk("R10 sleep ignored", {31'b0, sleep_o}, 32'h0);
      clear(32'h0000_0010);
      do_wr(EN, 32'hC408_011A);

      // R6: sleep write and enabled edge in the same cycle
      @(negedge clk); reg_wr = 1'b1; reg_addr = CT; reg_wdata = 32'h1; trig_in = 32'h0400_0000;
      @(negedge clk); reg_wr = 1'b0; trig_in = 32'h0;
      chk("R6 wake wins", {31'b0, sleep_o}, 32'h0);
      chk("R6 irq", {31'b0, wake_irq_o}, 32'h1);
      clear(32'h0400_0000);
      chk("R7 irq clear", {31'b0, wake_irq_o}, 32'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule